// File: doc/BRIEF.md
# Multi-width write transmit byte queue

This block is the transmit-side staging buffer of a serial-style peripheral. Software feeds it through a small register port. Three push addresses accept one, two or four bytes in a single write. A level register reports how many bytes are waiting. On the other side, a valid/ready byte stream hands the bytes one at a time to a downstream serializer.

The queue holds sixteen bytes. It has no programmable low-water mark. The only transmit event is the moment the last waiting byte leaves, that is, when the level steps from one to zero. This event is latched in a sticky status bit, and the interrupt line is that bit gated by an enable. A push that does not fit is dropped whole, and the drop is recorded in a second sticky bit. Software clears both bits by writing ones to them.

Register addresses on `reg_addr`:

| Address | Access | Use |
|---|---|---|
| 0 | write | push one byte |
| 1 | write | push two bytes |
| 2 | write | push four bytes |
| 3 | read | current level |
| 4 | read, write one to clear | status |
| 5 | read/write | control |

Top module: `mwtx_fifo`

## Requirements
- R1: After reset the level reads 0, status reads 0, control reads 0, `out_valid` is low and `irq` is low.
- R2: A write to address 0 enqueues `reg_wdata[7:0]`. A write to address 1 enqueues `reg_wdata[15:0]` as two bytes. A write to address 2 enqueues `reg_wdata[31:0]` as four bytes. The level grows by 1, 2 or 4 respectively, and any upper write data is ignored.
- R3: A read of address 3 returns the level (0 to 16) in bits [4:0], with all other bits zero. The level never exceeds 16.
- R4: Bytes of a multi-byte push leave the queue least-significant byte first, and pushes leave in the order they were written.
- R5: Status bit 0 (drained, address 4) sets only in a cycle where the level goes from 1 to 0. It does not set while the queue sits empty, and it does not set when a push lands in the same cycle as the last byte's removal.
- R6: Status bits are sticky until software writes 1 to them at address 4. Bit 0 clears the drained flag, and bit 1 clears the overflow flag.
- R7: If the level before a push plus the push's byte count exceeds 16, the whole push is discarded (same-cycle removal is not counted as room). The level is unchanged apart from any removal, and status bit 1 (overflow) sets.
- R8: `irq` equals status bit 0 ANDed with control bit 0 (address 5, read back in bit 0).
- R9: `out_valid` is high exactly when the level is nonzero. `out_data` shows the oldest byte, and one byte is removed in each cycle where `out_valid` and `out_ready` are both high.
- R10: A push and a removal in the same cycle change the level by the push count minus one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| out_valid | output | 1 | A byte is available |
| out_ready | input | 1 | Downstream takes the byte this cycle |
| out_data | output | 8 | Oldest queued byte |
| irq | output | 1 | Transmit-drained interrupt |

## Verification
The hardest case to reach is the removal of the last byte in the very cycle a new push lands. Here the level passes through one but never reaches zero, and no drained event may be recorded. The stimulus first drains the queue down to a single byte. It then raises `out_ready` and a one-byte push together on the same edge. Afterwards it checks that the level still reads one, the drained bit is clear and the new byte is at the head. Overflow is reached by filling to fourteen bytes and pushing four, so the discard is a partial-fit case rather than a push into a full queue.

// File: rtl/mwtx_pkg.sv
package mwtx_pkg;
  typedef enum logic [2:0] {
    A_PUSH1  = 3'd0,
    A_PUSH2  = 3'd1,
    A_PUSH4  = 3'd2,
    A_LEVEL  = 3'd3,
    A_STATUS = 3'd4,
    A_CTRL   = 3'd5
  } reg_sel_e;

  localparam int unsigned MAX_LANES = 4;
  localparam int unsigned STS_DRAINED = 0;
  localparam int unsigned STS_OVERRUN = 1;
endpackage

// File: rtl/mwtx_rst_sync.sv
module mwtx_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) chain_q <= '0;
    else              chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/mwtx_regif.sv
module mwtx_regif
  import mwtx_pkg::*;
#(
  parameter int unsigned LW = 5,
  parameter int unsigned CW = 3
) (
  input  logic          reg_we,
  input  logic [2:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  input  logic [LW-1:0] level,
  input  logic          sts_drained,
  input  logic          sts_overrun,
  input  logic          ctrl_en,
  output logic          push_req,
  output logic [CW-1:0] push_cnt,
  output logic [31:0]   push_bytes,
  output logic [1:0]    clr_mask,
  output logic          ctrl_we,
  output logic          ctrl_wval,
  output logic [31:0]   reg_rdata
);
  always_comb begin
    push_req   = 1'b0;
    push_cnt   = '0;
    push_bytes = reg_wdata;
    clr_mask   = 2'b00;
    ctrl_we    = 1'b0;
    ctrl_wval  = reg_wdata[0];
    if (reg_we) begin
      unique case (reg_addr)
        A_PUSH1:  begin push_req = 1'b1; push_cnt = CW'(1); end
        A_PUSH2:  begin push_req = 1'b1; push_cnt = CW'(2); end
        A_PUSH4:  begin push_req = 1'b1; push_cnt = CW'(4); end
        A_STATUS: clr_mask = reg_wdata[1:0];
        A_CTRL:   ctrl_we = 1'b1;
        default:  ;
      endcase
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      A_LEVEL:  reg_rdata = 32'(level);
      A_STATUS: begin
        reg_rdata[STS_DRAINED] = sts_drained;
        reg_rdata[STS_OVERRUN] = sts_overrun;
      end
      A_CTRL:   reg_rdata[0] = ctrl_en;
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/mwtx_store.sv
module mwtx_store #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned LANES = 4,
  parameter int unsigned PW    = $clog2(DEPTH),
  parameter int unsigned LW    = $clog2(DEPTH + 1),
  parameter int unsigned CW    = $clog2(LANES + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               push_req,
  input  logic [CW-1:0]      push_cnt,
  input  logic [8*LANES-1:0] push_bytes,
  input  logic               pop_ready,
  output logic               out_valid,
  output logic [7:0]         out_data,
  output logic [LW-1:0]      level,
  output logic               push_ok,
  output logic               push_rej,
  output logic               pop_fire
);
  localparam int unsigned NW = LW + 1;

  logic [7:0]    mem [DEPTH];
  logic [PW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [LW-1:0] lvl_q, lvl_d;
  logic [NW-1:0] need;
  logic [LANES-1:0] lane_wr;
  logic [PW-1:0]    lane_idx [LANES];

  function automatic logic [PW-1:0] ring_add(input logic [PW-1:0] p, input int unsigned k);
    int unsigned s;
    s = int'(p) + k;
    if (s >= DEPTH) s = s - DEPTH;
    return PW'(s);
  endfunction

  always_comb begin
    need      = NW'(lvl_q) + NW'(push_cnt);
    push_ok   = push_req && (need <= NW'(DEPTH));
    push_rej  = push_req && !push_ok;
    out_valid = (lvl_q != '0);
    pop_fire  = out_valid && pop_ready;
    lvl_d     = lvl_q;
    wp_d      = wp_q;
    rp_d      = rp_q;
    if (push_ok) begin
      lvl_d = lvl_d + LW'(push_cnt);
      wp_d  = ring_add(wp_q, int'(push_cnt));
    end
    if (pop_fire) begin
      lvl_d = lvl_d - LW'(1);
      rp_d  = ring_add(rp_q, 1);
    end
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign lane_wr[k]  = push_ok && (CW'(k) < push_cnt);
    assign lane_idx[k] = ring_add(wp_q, k);
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < LANES; k++) begin
      if (lane_wr[k]) mem[lane_idx[k]] <= push_bytes[8*k +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= '0;
      wp_q  <= '0;
      rp_q  <= '0;
    end else begin
      lvl_q <= lvl_d;
      wp_q  <= wp_d;
      rp_q  <= rp_d;
    end
  end

  assign out_data = mem[rp_q];
  assign level    = lvl_q;

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_q <= LW'(DEPTH)); // R3
  AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && !pop_fire) |=> (lvl_q == $past(lvl_q) + LW'($past(push_cnt)))); // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push_rej |=> (lvl_q == $past(lvl_q) - LW'($past(pop_fire)))); // R7
  AST_BOTH_WAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && pop_fire) |=> (lvl_q == $past(lvl_q) + LW'($past(push_cnt)) - LW'(1))); // R10
endmodule

// File: rtl/mwtx_events.sv
module mwtx_events #(
  parameter int unsigned LW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [LW-1:0] level_i,
  input  logic          pop_fire,
  input  logic          push_ok,
  input  logic          push_rej,
  input  logic [1:0]    clr_mask,
  input  logic          ctrl_we,
  input  logic          ctrl_wval,
  output logic          sts_drained,
  output logic          sts_overrun,
  output logic          ctrl_en,
  output logic          irq
);
  logic drained_q, drained_d;
  logic overrun_q, overrun_d;
  logic en_q, en_d;
  logic last_out;

  always_comb begin
    last_out  = pop_fire && !push_ok && (level_i == LW'(1));
    drained_d = drained_q;
    overrun_d = overrun_q;
    en_d      = en_q;
    if (clr_mask[0]) drained_d = 1'b0;
    if (clr_mask[1]) overrun_d = 1'b0;
    if (last_out)    drained_d = 1'b1;
    if (push_rej)    overrun_d = 1'b1;
    if (ctrl_we)     en_d      = ctrl_wval;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drained_q <= 1'b0;
      overrun_q <= 1'b0;
      en_q      <= 1'b0;
    end else begin
      drained_q <= drained_d;
      overrun_q <= overrun_d;
      en_q      <= en_d;
    end
  end

  assign sts_drained = drained_q;
  assign sts_overrun = overrun_q;
  assign ctrl_en     = en_q;
  assign irq         = drained_q && en_q;

  AST_DRAIN_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drained_q) |-> ($past(level_i) == LW'(1) && level_i == '0)); // R5
  AST_DRAIN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (drained_q && !clr_mask[0]) |=> drained_q); // R6
  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun_q && !clr_mask[1]) |=> overrun_q); // R6
endmodule

// File: rtl/mwtx_fifo.sv
module mwtx_fifo #(
  parameter int unsigned DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [7:0]  out_data,
  output logic        irq
);
  localparam int unsigned LANES = mwtx_pkg::MAX_LANES;
  localparam int unsigned LW    = $clog2(DEPTH + 1);
  localparam int unsigned CW    = $clog2(LANES + 1);

  logic          srst_n;
  logic          push_req, push_ok, push_rej, pop_fire;
  logic [CW-1:0] push_cnt;
  logic [31:0]   push_bytes;
  logic [LW-1:0] level;
  logic [1:0]    clr_mask;
  logic          ctrl_we, ctrl_wval;
  logic          sts_drained, sts_overrun, ctrl_en;

  mwtx_rst_sync #(.STAGES(2)) i_rst (
    .clk(clk), .rst_n_async(rst_n), .rst_n_sync(srst_n)
  );

  mwtx_regif #(.LW(LW), .CW(CW)) i_regif (
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .level(level), .sts_drained(sts_drained), .sts_overrun(sts_overrun),
    .ctrl_en(ctrl_en), .push_req(push_req), .push_cnt(push_cnt),
    .push_bytes(push_bytes), .clr_mask(clr_mask), .ctrl_we(ctrl_we),
    .ctrl_wval(ctrl_wval), .reg_rdata(reg_rdata)
  );

  mwtx_store #(.DEPTH(DEPTH), .LANES(LANES)) i_store (
    .clk(clk), .rst_n(srst_n), .push_req(push_req), .push_cnt(push_cnt),
    .push_bytes(push_bytes), .pop_ready(out_ready), .out_valid(out_valid),
    .out_data(out_data), .level(level), .push_ok(push_ok),
    .push_rej(push_rej), .pop_fire(pop_fire)
  );

  mwtx_events #(.LW(LW)) i_events (
    .clk(clk), .rst_n(srst_n), .level_i(level), .pop_fire(pop_fire),
    .push_ok(push_ok), .push_rej(push_rej), .clr_mask(clr_mask),
    .ctrl_we(ctrl_we), .ctrl_wval(ctrl_wval), .sts_drained(sts_drained),
    .sts_overrun(sts_overrun), .ctrl_en(ctrl_en), .irq(irq)
  );
endmodule

// File: tb/test_mwtx_fifo.sv
`timescale 1ns/1ps
module test_mwtx_fifo;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [7:0]  out_data;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  mwtx_fifo i_mwtx_fifo (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .irq(irq)
  );

  localparam logic [2:0] P1 = 3'd0, P2 = 3'd1, P4 = 3'd2, LV = 3'd3, ST = 3'd4, CT = 3'd5;
  localparam logic [1:0] OW = 2'd0, ORD = 2'd1, OPOP = 2'd2;

  function automatic logic [68:0] mk(input logic [1:0] op, input logic [2:0] a,
                                     input logic [31:0] d, input logic [31:0] e);
    return {op, a, d, e};
  endfunction

  localparam int NV = 36;
  localparam logic [68:0] VEC [NV] = '{
    mk(ORD, LV, 0, 0),            mk(ORD, ST, 0, 0),
    mk(OW, CT, 1, 0),             mk(ORD, CT, 0, 1),
    mk(OW, P4, 32'h44332211, 0),  mk(ORD, LV, 0, 4),
    mk(OW, P2, 32'hAAAA6655, 0),  mk(OW, P1, 32'hBBBBBB77, 0),
    mk(ORD, LV, 0, 7),            mk(OPOP, 0, 0, 32'h11),
    mk(OPOP, 0, 0, 32'h22),       mk(OPOP, 0, 0, 32'h33),
    mk(OPOP, 0, 0, 32'h44),       mk(OPOP, 0, 0, 32'h55),
    mk(OPOP, 0, 0, 32'h66),       mk(ORD, ST, 0, 0),
    mk(ORD, LV, 0, 1),            mk(OPOP, 0, 0, 32'h77),
    mk(ORD, ST, 0, 1),            mk(ORD, LV, 0, 0),
    mk(OW, ST, 1, 0),             mk(ORD, ST, 0, 0),
    mk(OW, P4, 32'h03020100, 0),  mk(OW, P4, 32'h07060504, 0),
    mk(OW, P4, 32'h0B0A0908, 0),  mk(OW, P2, 32'h00000D0C, 0),
    mk(ORD, LV, 0, 14),           mk(OW, P4, 32'hFFFFFFFF, 0),
    mk(ORD, LV, 0, 14),           mk(ORD, ST, 0, 2),
    mk(OW, P2, 32'h00000F0E, 0),  mk(ORD, LV, 0, 16),
    mk(OW, P1, 32'h000000EE, 0),  mk(ORD, LV, 0, 16),
    mk(OW, ST, 2, 0),             mk(ORD, ST, 0, 0)
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input string req, input logic [2:0] a, input logic [31:0] e);
    reg_addr = a;
    #1;
    chk(req, reg_rdata, e);
  endtask

  task automatic pop(input string req, input logic [7:0] e);
    @(negedge clk);
    chk({req, " valid"}, 32'(out_valid), 1);
    chk(req, 32'(out_data), 32'(e));
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 valid", 32'(out_valid), 0);
    chk("R1 irq", 32'(irq), 0);

    // Vector walk: R2 R3 R4 R5 R6 R7 R9
    for (int i = 0; i < NV; i++) begin
      logic [1:0] op; logic [2:0] a; logic [31:0] d, e;
      {op, a, d, e} = VEC[i];
      case (op)
        OW:  wr(a, d);
        ORD: rd($sformatf("R3/R5/R6/R7 vec%0d", i), a, e);
        default: pop($sformatf("R2/R4/R9 vec%0d", i), e[7:0]);
      endcase
    end

    // R4: remaining bytes leave in push order, LSB first
    for (int b = 0; b < 16; b++) pop("R4 order", 8'(b));
    @(negedge clk);
    chk("R9 empty valid", 32'(out_valid), 0);
    rd("R5 drained", ST, 1);
    chk("R8 irq on", 32'(irq), 1);
    wr(CT, 0);
    chk("R8 irq masked", 32'(irq), 0);
    wr(ST, 1);
    wr(CT, 1);
    repeat (5) @(negedge clk);
    rd("R5 idle empty", ST, 0);
    chk("R8 irq idle", 32'(irq), 0);

    // R10 / R5: push lands with removal of the last byte
    wr(P1, 32'h42);
    rd("R3 one", LV, 1);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = P1; reg_wdata = 32'h5A; out_ready = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; out_ready = 1'b0;
    rd("R10 level", LV, 1);
    rd("R5 no drain", ST, 0);
    chk("R10 head", 32'(out_data), 32'h5A);
    pop("R9 pop", 8'h5A);
    rd("R5 drain", ST, 1);

    // R1: reset mid-operation
    wr(P4, 32'h01020304);
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    rd("R1 level", LV, 0);
    rd("R1 status", ST, 0);
    rd("R1 ctrl", CT, 0);
    chk("R1 valid", 32'(out_valid), 0);
    chk("R1 irq", 32'(irq), 0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule